// File: doc/BRIEF.md
# Masked Control Register File

This block holds the control registers of a small processor core: 32 word-wide slots addressed by a 5-bit index. Software reaches them through a single-word write port, an even-aligned 64-bit pair write port, and two combinational read ports, one for a word and one for a pair. Each slot has a fixed write-protect mask. On a software write, every protected bit keeps its current value and only the unprotected bits take the new data. A slot with an all-zero mask is fully writable.

Some slots are special. The program-counter slot has no storage: software writes to it are dropped, and a read returns the fetch-stage PC input. Slot 4 has no storage either. It is a packed view of four 8-bit predicate registers, and a write to it spreads the word across them. The cycle-count and timer slots cannot be written by software. They change only through a separate load port that bypasses the masks, which stands in for the counter logic attached later.

A pair write with an odd base index is rejected. Rejection is reported by a one-cycle error strobe.

Top module: `ctrlreg_file`

## Requirements
- R1: After a synchronous active-low reset, every stored slot and all four predicates read as zero.
- R2: A software write stores (new & ~mask) | (current & mask). The user status slot, index 8, has mask 0xC13000C0, so an all-ones write from reset reads back 0x3ECFFF3F.
- R3: The global pointer slot, index 11, has mask 0x0000003F, so an all-ones write from reset reads back 0xFFFFFFC0. Index 10 is fully writable.
- R4: The cycle-count slots (14 low, 15 high) and the timer slots (30 low, 31 high) are fully protected. An all-ones software write leaves them at zero.
- R5: Writes to index 9 are discarded, and a read of index 9 returns the `fetch_pc` input in the same cycle.
- R6: A pair write with even base N sends data bits 31:0 to index N and bits 63:32 to index N+1, each half masked with its own slot's mask. All ones to pair 10 reads back 0xFFFFFFC0_FFFFFFFF; all ones to pair 14 or pair 30 reads back zero.
- R7: A read of index 4 returns {P3,P2,P1,P0}, with P0 in bits 7:0. A write to index 4 loads P0 from bits 7:0 up to P3 from bits 31:24.
- R8: A pair read at base 4 returns the packed predicate word in bits 31:0 and slot 5 in bits 63:32.
- R9: The loop and modifier slots (0, 1, 2, 3, 6, 7) are fully writable.
- R10: A pair write with an odd base index changes no slot. `pair_err` is high for exactly the one cycle after it.
- R11: The load port writes its data unmasked, only into indices 14, 15, 30 and 31; a load aimed at any other index has no effect. In the same cycle as a software write to the same slot, the load wins.
- R12: When the word port and the pair port address the same slot in one cycle, the word port's data is stored; the other half of the pair is still written.
- R13: The pair read port ignores bit 0 of its index and reads the even-aligned pair {slot N+1, slot N}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Word write strobe |
| wr_idx | input | 5 | Word write index |
| wr_data | input | 32 | Word write data |
| pw_en | input | 1 | Pair write strobe |
| pw_idx | input | 5 | Pair write base index (must be even) |
| pw_data | input | 64 | Pair write data, high word to base+1 |
| ld_en | input | 1 | Counter/timer load strobe (bypasses masks) |
| ld_idx | input | 5 | Load target index |
| ld_data | input | 32 | Load data |
| fetch_pc | input | 32 | Current PC from the fetch stage |
| rd_idx | input | 5 | Word read index |
| rd_data | output | 32 | Word read data (combinational) |
| prd_idx | input | 5 | Pair read index (bit 0 ignored) |
| prd_data | output | 64 | Pair read data (combinational) |
| pair_err | output | 1 | One-cycle strobe after an odd-base pair write |

## Verification
The word port and the pair port can both land on the same slot in one clock, and the load port can meet a software write on a counter slot in the same way. The bench provokes both. In one cycle it writes slot 1 through the word port and pair 0:1 through the pair port. In another cycle it pairs a load with an all-ones software write to timer slot 30. The first case passes when slot 1 holds the word data and slot 0 holds the pair's low half. The second passes when slot 30 holds exactly the load value.

// File: rtl/ctrlreg_pkg.sv
// Shared constants and per-index attributes for the masked control register file.
// Assumes a 5-bit index space and 32-bit registers.
package ctrlreg_pkg;
    localparam int unsigned CR_W    = 32;
    localparam int unsigned CR_N    = 32;
    localparam int unsigned CR_IW   = $clog2(CR_N);
    localparam int unsigned PRED_N  = 4;
    localparam int unsigned PRED_W  = CR_W / PRED_N;

    localparam int unsigned IDX_PRED   = 4;
    localparam int unsigned IDX_USR    = 8;
    localparam int unsigned IDX_PC     = 9;
    localparam int unsigned IDX_GP     = 11;
    localparam int unsigned IDX_CYC_LO = 14;
    localparam int unsigned IDX_CYC_HI = 15;
    localparam int unsigned IDX_TMR_LO = 30;
    localparam int unsigned IDX_TMR_HI = 31;

    // True for slots that only the load port may change.
    function automatic bit is_counter(int unsigned idx);
        return (idx == IDX_CYC_LO) || (idx == IDX_CYC_HI) ||
               (idx == IDX_TMR_LO) || (idx == IDX_TMR_HI);
    endfunction

    // Protected-bit mask of a slot; zero means fully writable.
    function automatic logic [CR_W-1:0] prot_mask(int unsigned idx);
        if (is_counter(idx) || idx == IDX_PC) return '1;
        if (idx == IDX_USR)                   return 32'hC130_00C0;
        if (idx == IDX_GP)                    return 32'h0000_003F;
        return '0;
    endfunction

    // True for slots backed by their own flops.
    function automatic bit has_storage(int unsigned idx);
        return (idx != IDX_PRED) && (idx != IDX_PC);
    endfunction
endpackage

// File: rtl/ctrl_wr_decode.sv
// Turns the word and pair write ports into one enable and one data word per slot.
// Word port has priority on a shared slot; odd-base pair writes are dropped
// and flagged combinationally through pair_bad.
module ctrl_wr_decode
    import ctrlreg_pkg::*;
#(
    parameter int unsigned W  = CR_W,
    parameter int unsigned N  = CR_N,
    parameter int unsigned IW = CR_IW
) (
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [W-1:0]          wr_data,
    input  logic                  pw_en,
    input  logic [IW-1:0]         pw_idx,
    input  logic [2*W-1:0]        pw_data,
    output logic [N-1:0]          slot_we,
    output logic [N-1:0][W-1:0]   slot_wd,
    output logic                  pair_bad
);
    logic pair_ok;

    // Classify the pair request.
    always_comb begin
        pair_ok  = pw_en && !pw_idx[0];
        pair_bad = pw_en &&  pw_idx[0];
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        localparam logic [IW-1:0] SLOT = IW'(i);
        logic hit_word, hit_lo, hit_hi;
        // Per-slot hit detection and data selection, word port first.
        always_comb begin
            hit_word = wr_en && (wr_idx == SLOT);
            hit_lo   = pair_ok && (pw_idx == SLOT);
            hit_hi   = pair_ok && ((pw_idx | IW'(1)) == SLOT) && SLOT[0];
            slot_we[i] = hit_word || hit_lo || hit_hi;
            if (hit_word)    slot_wd[i] = wr_data;
            else if (hit_lo) slot_wd[i] = pw_data[W-1:0];
            else             slot_wd[i] = pw_data[2*W-1:W];
        end
    end
endmodule

// File: rtl/ctrl_reg_slot.sv
// One control register with a fixed protected-bit mask and an optional
// mask-bypassing load port (used for counter/timer slots). Load beats write.
module ctrl_reg_slot #(
    parameter int unsigned   W        = 32,
    parameter logic [W-1:0]  MASK     = '0,
    parameter bit            LOADABLE = 1'b0,
    parameter string         TAG      = "slot"
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wd,
    input  logic         ld_en,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] q
);
    logic ld_act;

    // Load is only honoured on loadable slots.
    always_comb ld_act = LOADABLE && ld_en;

    // Register update: reset, load, or masked merge.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (ld_act) q <= ld_data;
        else if (we)     q <= (wd & ~MASK) | (q & MASK);
    end

    // R2: protected bits survive a software write
    assert_protected_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ld_act) |=> ((q & MASK) == ($past(q) & MASK)));

    // R2: unprotected bits take the written data
    assert_open_bits_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ld_act) |=> ((q & ~MASK) == ($past(wd) & ~MASK)));

    // R11: a load stores its data unmasked
    assert_load_stores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_act |=> (q == $past(ld_data)));
endmodule

// File: rtl/ctrl_pred_bank.sv
// Four 8-bit predicate registers seen through one packed word (P0 in the
// low byte). A write to the alias spreads the word across the four.
module ctrl_pred_bank
    import ctrlreg_pkg::*;
#(
    parameter int unsigned PN = PRED_N,
    parameter int unsigned PW = PRED_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [PN*PW-1:0] wd,
    output logic [PN*PW-1:0] packed_q
);
    for (genvar p = 0; p < PN; p++) begin : g_pred
        logic [PW-1:0] pr;
        // Hold one predicate, loaded from its byte of the alias word.
        always_ff @(posedge clk) begin
            if (!rst_n)  pr <= '0;
            else if (we) pr <= wd[p*PW +: PW];
        end
        always_comb packed_q[p*PW +: PW] = pr;
    end

    // R7: the packed view returns what the alias write split
    assert_pred_roundtrip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (packed_q == $past(wd)));

    // R7: predicates hold when not written
    assert_pred_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(packed_q));
endmodule

// File: rtl/ctrl_read_mux.sv
// Combinational word and pair read paths. Resolves the predicate alias and the
// PC slot; the pair path forces an even base.
module ctrl_read_mux
    import ctrlreg_pkg::*;
#(
    parameter int unsigned W  = CR_W,
    parameter int unsigned N  = CR_N,
    parameter int unsigned IW = CR_IW
) (
    input  logic [N-1:0][W-1:0] slot_q,
    input  logic [W-1:0]        pred_word,
    input  logic [W-1:0]        fetch_pc,
    input  logic [IW-1:0]       rd_idx,
    input  logic [IW-1:0]       prd_idx,
    output logic [W-1:0]        rd_data,
    output logic [2*W-1:0]      prd_data
);
    localparam logic [IW-1:0] I_PRED = IW'(IDX_PRED);
    localparam logic [IW-1:0] I_PC   = IW'(IDX_PC);

    // Value of one slot as software sees it.
    function automatic logic [W-1:0] view(input logic [IW-1:0] idx,
                                          input logic [N-1:0][W-1:0] sq,
                                          input logic [W-1:0] pw,
                                          input logic [W-1:0] pc);
        if (idx == I_PRED) return pw;
        if (idx == I_PC)   return pc;
        return sq[idx];
    endfunction

    logic [IW-1:0] base_lo, base_hi;

    // Drive both read ports.
    always_comb begin
        base_lo  = {prd_idx[IW-1:1], 1'b0};
        base_hi  = {prd_idx[IW-1:1], 1'b1};
        rd_data  = view(rd_idx, slot_q, pred_word, fetch_pc);
        prd_data = {view(base_hi, slot_q, pred_word, fetch_pc),
                    view(base_lo, slot_q, pred_word, fetch_pc)};
    end
endmodule

// File: rtl/ctrlreg_file.sv
// Top of the masked control register file: write decode, one slot per stored
// index, the predicate bank behind the alias, read muxing and the odd-pair
// error strobe. Assumes the counter/timer logic drives the load port.
module ctrlreg_file
    import ctrlreg_pkg::*;
#(
    parameter int unsigned W  = CR_W,
    parameter int unsigned N  = CR_N,
    parameter int unsigned IW = CR_IW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [W-1:0]   wr_data,
    input  logic           pw_en,
    input  logic [IW-1:0]  pw_idx,
    input  logic [2*W-1:0] pw_data,
    input  logic           ld_en,
    input  logic [IW-1:0]  ld_idx,
    input  logic [W-1:0]   ld_data,
    input  logic [W-1:0]   fetch_pc,
    input  logic [IW-1:0]  rd_idx,
    output logic [W-1:0]   rd_data,
    input  logic [IW-1:0]  prd_idx,
    output logic [2*W-1:0] prd_data,
    output logic           pair_err
);
    logic [N-1:0]         slot_we;
    logic [N-1:0][W-1:0]  slot_wd;
    logic [N-1:0][W-1:0]  slot_q;
    logic [W-1:0]         pred_word;
    logic                 pair_bad;

    ctrl_wr_decode #(.W(W), .N(N), .IW(IW)) u_dec (
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
        .slot_we(slot_we), .slot_wd(slot_wd), .pair_bad(pair_bad)
    );

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == IDX_PRED) begin : g_alias
            ctrl_pred_bank u_pred (
                .clk(clk), .rst_n(rst_n),
                .we(slot_we[i]), .wd(slot_wd[i]), .packed_q(pred_word)
            );
            always_comb slot_q[i] = '0;
        end else if (i == IDX_PC) begin : g_pc
            always_comb slot_q[i] = '0;
            // R5: a write aimed at the PC leaves the PC read path on fetch_pc
            assert_pc_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_we[i] && rd_idx == IW'(IDX_PC)) |-> (rd_data == fetch_pc));
        end else begin : g_store
            logic ld_hit;
            // Route the load port to this slot when it targets it.
            always_comb ld_hit = ld_en && (ld_idx == IW'(i));
            ctrl_reg_slot #(
                .W(W), .MASK(prot_mask(i)), .LOADABLE(is_counter(i))
            ) u_slot (
                .clk(clk), .rst_n(rst_n),
                .we(slot_we[i]), .wd(slot_wd[i]),
                .ld_en(ld_hit), .ld_data(ld_data), .q(slot_q[i])
            );
        end
    end

    ctrl_read_mux #(.W(W), .N(N), .IW(IW)) u_rd (
        .slot_q(slot_q), .pred_word(pred_word), .fetch_pc(fetch_pc),
        .rd_idx(rd_idx), .prd_idx(prd_idx),
        .rd_data(rd_data), .prd_data(prd_data)
    );

    // One-cycle strobe after an odd-base pair write.
    always_ff @(posedge clk) begin
        if (!rst_n) pair_err <= 1'b0;
        else        pair_err <= pair_bad;
    end

    // R10: odd-base pair write raises the strobe next cycle
    assert_odd_pair_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en && pw_idx[0]) |=> pair_err);

    // R10: strobe never follows a cycle without an odd pair write
    assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pw_en && pw_idx[0]) |=> !pair_err);

    // R5: PC reads follow the fetch stage
    assert_pc_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IW'(IDX_PC)) |-> (rd_data == fetch_pc));
endmodule

// File: tb/sim_ctrlreg_file.sv
module sim_ctrlreg_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        pw_en = 1'b0;
    logic [4:0]  pw_idx = '0;
    logic [63:0] pw_data = '0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] fetch_pc = 32'h0000_1000;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [4:0]  prd_idx = '0;
    logic [63:0] prd_data;
    logic        pair_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ctrlreg_file u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .fetch_pc(fetch_pc),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .prd_idx(prd_idx), .prd_data(prd_data),
        .pair_err(pair_err)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Advance one edge; inputs are driven and results sampled at negedges.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr1(input logic [4:0] i, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic wr2(input logic [4:0] i, input logic [63:0] d);
        pw_en = 1'b1; pw_idx = i; pw_data = d;
        tick();
        pw_en = 1'b0;
    endtask

    task automatic rd1(input logic [4:0] i, output logic [31:0] v);
        rd_idx = i; #1; v = rd_data;
    endtask

    task automatic rd2(input logic [4:0] i, output logic [63:0] v);
        prd_idx = i; #1; v = prd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic [63:0] p;
        for (int i = 0; i < 32; i++) begin
            rd1(5'(i), v);
            chk("R1 reset", {32'h0, v}, (i == 9) ? 64'h1000 : 64'h0);
        end
        rd2(5'd4, p); chk("R1 reset predicates", p, 64'h0);
        chk("R10 no strobe after reset", {63'h0, pair_err}, 64'h0);
    endtask

    task automatic t_usr();
        logic [31:0] v;
        wr1(5'd8, 32'hFFFF_FFFF); rd1(5'd8, v);
        chk("R2 usr all ones", {32'h0, v}, 64'h3ECF_FF3F);
        wr1(5'd8, 32'h0); rd1(5'd8, v);
        chk("R2 usr cleared", {32'h0, v}, 64'h0);
    endtask

    task automatic t_gp();
        logic [31:0] v;
        wr1(5'd11, 32'hFFFF_FFFF); rd1(5'd11, v);
        chk("R3 gp all ones", {32'h0, v}, 64'hFFFF_FFC0);
        wr1(5'd10, 32'hFFFF_FFFF); rd1(5'd10, v);
        chk("R3 index 10 writable", {32'h0, v}, 64'hFFFF_FFFF);
    endtask

    task automatic t_counters();
        logic [31:0] v;
        logic [4:0] idx [4] = '{5'd14, 5'd15, 5'd30, 5'd31};
        for (int k = 0; k < 4; k++) begin
            wr1(idx[k], 32'hFFFF_FFFF); rd1(idx[k], v);
            chk("R4 counter protected", {32'h0, v}, 64'h0);
        end
    endtask

    task automatic t_pc();
        logic [31:0] v;
        fetch_pc = 32'h0040_0010;
        wr1(5'd9, 32'h0); rd1(5'd9, v);
        chk("R5 pc write dropped", {32'h0, v}, 64'h0040_0010);
        fetch_pc = 32'h0000_1234; rd1(5'd9, v);
        chk("R5 pc follows fetch", {32'h0, v}, 64'h1234);
    endtask

    task automatic t_pair();
        logic [63:0] p;
        wr2(5'd10, 64'hFFFF_FFFF_FFFF_FFFF); rd2(5'd10, p);
        chk("R6 pair 10", p, 64'hFFFF_FFC0_FFFF_FFFF);
        wr2(5'd14, 64'hFFFF_FFFF_FFFF_FFFF); rd2(5'd14, p);
        chk("R6 pair 14", p, 64'h0);
        wr2(5'd30, 64'hFFFF_FFFF_FFFF_FFFF); rd2(5'd30, p);
        chk("R6 pair 30", p, 64'h0);
        wr2(5'd6, 64'h1234_5678_9ABC_DEF0); rd2(5'd6, p);
        chk("R6 pair 6 split", p, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_pred();
        logic [31:0] v;
        logic [63:0] p;
        wr1(5'd4, 32'hA1B2_C3D4); rd1(5'd4, v);
        chk("R7 alias roundtrip", {32'h0, v}, 64'hA1B2_C3D4);
        wr1(5'd5, 32'h0000_0055); rd2(5'd4, p);
        chk("R8 pair read at alias", p, 64'h0000_0055_A1B2_C3D4);
        wr2(5'd4, 64'h0000_0077_1122_3344); rd2(5'd4, p);
        chk("R7 R8 pair write at alias", p, 64'h0000_0077_1122_3344);
    endtask

    task automatic t_loop();
        logic [31:0] v;
        logic [4:0] idx [6] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd6, 5'd7};
        for (int k = 0; k < 6; k++) wr1(idx[k], 32'hF0F0_0000 | 32'(k * 17 + 1));
        for (int k = 0; k < 6; k++) begin
            rd1(idx[k], v);
            chk("R9 loop/modifier writable", {32'h0, v}, {32'h0, 32'hF0F0_0000 | 32'(k * 17 + 1)});
        end
    endtask

    task automatic t_odd_pair();
        logic [63:0] p, q;
        rd2(5'd6, p); rd2(5'd8, q);
        pw_en = 1'b1; pw_idx = 5'd7; pw_data = '1;
        tick();
        pw_en = 1'b0;
        chk("R10 strobe high", {63'h0, pair_err}, 64'h1);
        rd2(5'd6, pw_data); chk("R10 pair 6 untouched", pw_data, p);
        rd2(5'd8, pw_data); chk("R10 pair 8 untouched", pw_data, q);
        tick();
        chk("R10 strobe one cycle", {63'h0, pair_err}, 64'h0);
    endtask

    task automatic t_load();
        logic [31:0] v, m0;
        ld_en = 1'b1; ld_idx = 5'd14; ld_data = 32'hDEAD_0001;
        tick(); ld_en = 1'b0;
        rd1(5'd14, v); chk("R11 load counter", {32'h0, v}, 64'hDEAD_0001);
        rd1(5'd6, m0);
        ld_en = 1'b1; ld_idx = 5'd6; ld_data = 32'h0BAD_0BAD;
        tick(); ld_en = 1'b0;
        rd1(5'd6, v); chk("R11 load ignored off counters", {32'h0, v}, {32'h0, m0});
        ld_en = 1'b1; ld_idx = 5'd30; ld_data = 32'h0000_CAFE;
        wr_en = 1'b1; wr_idx = 5'd30; wr_data = 32'hFFFF_FFFF;
        tick(); ld_en = 1'b0; wr_en = 1'b0;
        rd1(5'd30, v); chk("R11 load beats write", {32'h0, v}, 64'hCAFE);
        wr1(5'd14, 32'h0); rd1(5'd14, v);
        chk("R11 R4 loaded counter holds", {32'h0, v}, 64'hDEAD_0001);
    endtask

    task automatic t_collide();
        logic [63:0] p;
        wr_en = 1'b1; wr_idx = 5'd1; wr_data = 32'h0000_0011;
        pw_en = 1'b1; pw_idx = 5'd0; pw_data = 64'h0000_0022_0000_0033;
        tick(); wr_en = 1'b0; pw_en = 1'b0;
        rd2(5'd0, p); chk("R12 word port wins", p, 64'h0000_0011_0000_0033);
    endtask

    task automatic t_odd_read();
        logic [63:0] p, e;
        rd2(5'd6, e);
        rd2(5'd7, p); chk("R13 odd pair read aligned", p, e);
        rd2(5'd11, p); chk("R13 odd pair read 11", p, 64'hFFFF_FFC0_FFFF_FFFF);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_usr();
        t_gp();
        t_counters();
        t_pc();
        t_pair();
        t_pred();
        t_loop();
        t_odd_pair();
        t_load();
        t_collide();
        t_odd_read();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule